// File: doc/BRIEF.md
# Programmable Flag Offset Register Unit

This block keeps the two threshold offsets used by a FIFO's almost-empty and almost-full flag logic. The offsets are exported continuously so that the comparison logic can use them, while the storage and comparison themselves live elsewhere. While master reset is active, the level of a single offset-select input picks the default value of both offsets and the only loading method allowed until the next master reset. A low level selects a default of 127 with parallel loading. A high level selects a default of 1023 with serial loading.

After reset, a low offset-select input steers the write, read and serial enables to the offset registers rather than to FIFO memory. In parallel mode, write cycles take the data bus into the empty offset and then the full offset, through a write pointer that alternates between the two. In serial mode, one bit per clock edge goes from a one-bit input into a fixed sequence that covers both registers. Parallel read-back through an alternating read pointer works in either mode. A partial reset brings the access sequences back to their start and leaves the offsets and the mode untouched.

Top module: `ofs_prog_unit`

## Requirements
- R1: With `mrst` high and `ofs_sel_n` low at the last reset edge, both offsets become 0x07F on the next edge and parallel mode is latched.
- R2: With `mrst` high and `ofs_sel_n` high at the last reset edge, both offsets become 0x3FF and serial mode is latched.
- R3: `prst` (without `mrst`) keeps both offset values and the latched mode. It returns the write pointer, the read pointer and the serial bit position to their start, and it clears `dout` to zero.
- R4: In parallel mode, an edge with `ofs_sel_n` and `wr_en_n` both low writes `din[W-1:0]` into the empty offset when the write pointer is 0 and into the full offset when it is 1. The pointer then toggles, so writes alternate empty, full, empty and so on.
- R5: An edge with `ofs_sel_n` and `rd_en_n` both low loads `dout` with the zero-extended empty offset (read pointer 0) or full offset (read pointer 1), and the read pointer then toggles. This works in either mode. Otherwise `dout` holds its value.
- R6: In serial mode, an edge with `ofs_sel_n` and `ser_en_n` both low stores `ser_din` at sequence position k, which runs from 0 to 2W-1. Positions k < W go to empty-offset bit k, and the others go to full-offset bit k-W. After position 2W-1 the sequence restarts at 0. With `ser_en_n` high, nothing changes.
- R7: A write by the method that was not latched (a serial shift in parallel mode, or a parallel write in serial mode) changes neither offset.
- R8: While `ofs_sel_n` is high, the write, read and serial enables change neither the offsets nor `dout`.
- R9: When a parallel write and a read fall on the same edge, `dout` returns the register's value from before that write.
- R10: `mrst` takes priority over `prst`. It clears `dout` to zero and returns both pointers and the serial position to their start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mrst | input | 1 | Synchronous master reset, active high |
| prst | input | 1 | Synchronous partial reset, active high |
| ofs_sel_n | input | 1 | Offset-register select, active low; sampled as the mode/default choice during `mrst` |
| ser_en_n | input | 1 | Serial shift enable, active low |
| ser_din | input | 1 | Serial offset bit |
| wr_en_n | input | 1 | Write enable, active low |
| rd_en_n | input | 1 | Read enable, active low |
| din | input | DW | Parallel data bus |
| dout | output | DW | Registered read-back bus |
| empty_ofs | output | W | Almost-empty offset |
| full_ofs | output | W | Almost-full offset |

## Verification
The two functions that can fall on the same edge are a parallel offset write and a parallel offset read. Right after a master reset both pointers address the empty offset. The bench then asserts `wr_en_n` and `rd_en_n` together with a new data value. It expects `dout` to show the old default and the empty offset to take the new value. The read that follows must address the full offset, which shows that each pointer advanced exactly once.

// File: rtl/ofs_pkg.sv
package ofs_pkg;
  typedef enum logic {LOAD_PAR = 1'b0, LOAD_SER = 1'b1} load_mode_e;

  localparam int unsigned DEF_PAR_VAL = 127;
  localparam int unsigned DEF_SER_VAL = 1023;
  localparam int unsigned NUM_OFS = 2;
endpackage

// File: rtl/ofs_mode_latch.sv
module ofs_mode_latch
  import ofs_pkg::*;
(
  input  logic       clk,
  input  logic       mrst,
  input  logic       sel_level,
  output load_mode_e mode
);
  always_ff @(posedge clk) begin
    if (mrst) mode <= sel_level ? LOAD_SER : LOAD_PAR;
  end
endmodule

// File: rtl/ofs_toggle_ptr.sv
module ofs_toggle_ptr (
  input  logic clk,
  input  logic clr,
  input  logic adv,
  output logic ptr
);
  always_ff @(posedge clk) begin
    if (clr)      ptr <= 1'b0;
    else if (adv) ptr <= ~ptr;
  end
endmodule

// File: rtl/ofs_bit_cursor.sv
module ofs_bit_cursor #(
  parameter int unsigned W = 13
) (
  input  logic                 clk,
  input  logic                 clr,
  input  logic                 adv,
  output logic                 half,
  output logic [$clog2(W)-1:0] bit_idx
);
  localparam int unsigned N  = 2 * W;
  localparam int unsigned PW = $clog2(N);
  localparam int unsigned BW = $clog2(W);

  logic [PW-1:0] pos;
  logic [PW-1:0] rel;

  always_ff @(posedge clk) begin
    if (clr)      pos <= '0;
    else if (adv) pos <= (pos == PW'(N - 1)) ? '0 : pos + 1'b1;
  end

  always_comb begin
    half    = (pos >= PW'(W));
    rel     = half ? (pos - PW'(W)) : pos;
    bit_idx = rel[BW-1:0];
  end
endmodule

// File: rtl/ofs_prog_unit.sv
module ofs_prog_unit
  import ofs_pkg::*;
#(
  parameter int unsigned W  = 13,
  parameter int unsigned DW = 18
) (
  input  logic          clk,
  input  logic          mrst,
  input  logic          prst,
  input  logic          ofs_sel_n,
  input  logic          ser_en_n,
  input  logic          ser_din,
  input  logic          wr_en_n,
  input  logic          rd_en_n,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic [W-1:0]  empty_ofs,
  output logic [W-1:0]  full_ofs
);
  localparam int unsigned BW = $clog2(W);
  localparam logic [W-1:0] DEF_PAR = W'(DEF_PAR_VAL);
  localparam logic [W-1:0] DEF_SER = W'(DEF_SER_VAL);

  load_mode_e       mode;
  logic             wptr, rptr, clr_seq;
  logic             access, par_wr, ser_wr, rd_hit;
  logic             ser_half;
  logic [BW-1:0]    ser_bit;
  logic [W-1:0]     ofs_q [NUM_OFS];

  assign clr_seq = mrst | prst;
  assign access  = ~ofs_sel_n & ~clr_seq;
  assign par_wr  = access & ~wr_en_n  & (mode == LOAD_PAR);
  assign ser_wr  = access & ~ser_en_n & (mode == LOAD_SER);
  assign rd_hit  = access & ~rd_en_n;

  ofs_mode_latch u_mode (
    .clk(clk), .mrst(mrst), .sel_level(ofs_sel_n), .mode(mode)
  );

  ofs_toggle_ptr u_wptr (
    .clk(clk), .clr(clr_seq), .adv(par_wr), .ptr(wptr)
  );

  ofs_toggle_ptr u_rptr (
    .clk(clk), .clr(clr_seq), .adv(rd_hit), .ptr(rptr)
  );

  ofs_bit_cursor #(.W(W)) u_cursor (
    .clk(clk), .clr(clr_seq), .adv(ser_wr), .half(ser_half), .bit_idx(ser_bit)
  );

  for (genvar r = 0; r < NUM_OFS; r++) begin : g_ofs
    always_ff @(posedge clk) begin
      if (mrst)
        ofs_q[r] <= ofs_sel_n ? DEF_SER : DEF_PAR;
      else if (par_wr && (wptr == 1'(r)))
        ofs_q[r] <= din[W-1:0];
      else if (ser_wr && (ser_half == 1'(r)))
        ofs_q[r][ser_bit] <= ser_din;
    end
  end

  always_ff @(posedge clk) begin
    if (clr_seq)     dout <= '0;
    else if (rd_hit) dout <= DW'(ofs_q[rptr]);
  end

  assign empty_ofs = ofs_q[0];
  assign full_ofs  = ofs_q[1];
endmodule

// File: rtl/ofs_prog_chk.sv
module ofs_prog_chk #(
  parameter int unsigned W  = 13,
  parameter int unsigned DW = 18
) (
  input logic          clk,
  input logic          mrst,
  input logic          prst,
  input logic          ofs_sel_n,
  input logic          rd_en_n,
  input logic [DW-1:0] dout,
  input logic [W-1:0]  empty_ofs,
  input logic [W-1:0]  full_ofs
);
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  assert_defaults_par_R1: assert property (@(posedge clk) disable iff (!armed)
    (mrst && !ofs_sel_n) |=> (empty_ofs == W'(127) && full_ofs == W'(127)));

  assert_defaults_ser_R2: assert property (@(posedge clk) disable iff (!armed)
    (mrst && ofs_sel_n) |=> (empty_ofs == W'(1023) && full_ofs == W'(1023)));

  assert_partial_keeps_R3: assert property (@(posedge clk) disable iff (!armed)
    (prst && !mrst) |=> ($stable(empty_ofs) && $stable(full_ofs) && dout == '0));

  assert_read_hold_R5: assert property (@(posedge clk) disable iff (!armed)
    (!mrst && !prst && (ofs_sel_n || rd_en_n)) |=> $stable(dout));

  assert_deselected_R8: assert property (@(posedge clk) disable iff (!armed)
    (!mrst && ofs_sel_n) |=> ($stable(empty_ofs) && $stable(full_ofs)));

  assert_mrst_clears_R10: assert property (@(posedge clk) disable iff (!armed)
    mrst |=> (dout == '0));
endmodule

bind ofs_prog_unit ofs_prog_chk #(.W(W), .DW(DW)) u_chk (
  .clk(clk), .mrst(mrst), .prst(prst), .ofs_sel_n(ofs_sel_n),
  .rd_en_n(rd_en_n), .dout(dout), .empty_ofs(empty_ofs), .full_ofs(full_ofs)
);

// File: tb/sim_ofs_prog_unit.sv
`timescale 1ns/1ps
module sim_ofs_prog_unit;
  localparam int W  = 13;
  localparam int DW = 18;

  logic clk = 1'b0;
  logic mrst = 1'b0, prst = 1'b0, ofs_sel_n = 1'b1, ser_en_n = 1'b1, ser_din = 1'b0;
  logic wr_en_n = 1'b1, rd_en_n = 1'b1;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic [W-1:0]  empty_ofs, full_ofs;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ofs_prog_unit #(.W(W), .DW(DW)) u0 (
    .clk(clk), .mrst(mrst), .prst(prst), .ofs_sel_n(ofs_sel_n),
    .ser_en_n(ser_en_n), .ser_din(ser_din), .wr_en_n(wr_en_n),
    .rd_en_n(rd_en_n), .din(din), .dout(dout),
    .empty_ofs(empty_ofs), .full_ofs(full_ofs)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    mrst = 0; prst = 0; ofs_sel_n = 1; ser_en_n = 1; wr_en_n = 1; rd_en_n = 1;
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_mrst(input logic sel);
    idle(); mrst = 1; ofs_sel_n = sel; step(); step(); idle();
  endtask

  task automatic par_write(input logic [DW-1:0] v);
    ofs_sel_n = 0; wr_en_n = 0; din = v; step(); idle();
  endtask

  task automatic par_read();
    ofs_sel_n = 0; rd_en_n = 0; step(); idle();
  endtask

  task automatic ser_load(input logic [W-1:0] e, input logic [W-1:0] f);
    for (int i = 0; i < 2*W; i++) begin
      ofs_sel_n = 0; ser_en_n = 0;
      ser_din = (i < W) ? e[i] : f[i-W];
      step();
    end
    idle();
  endtask

  task automatic t_reset_par();
    do_mrst(1'b0);
    chk(empty_ofs, 127, "R1 empty default");
    chk(full_ofs, 127, "R1 full default");
    chk(dout, 0, "R10 dout after reset");
  endtask

  task automatic t_par_write();
    par_write(18'h3FFFF);
    par_write(18'h00ABC);
    chk(empty_ofs, 13'h1FFF, "R4 first write to empty, truncated");
    chk(full_ofs, 13'h0ABC, "R4 second write to full");
    par_write(18'h00011);
    chk(empty_ofs, 13'h0011, "R4 pointer wraps to empty");
    chk(full_ofs, 13'h0ABC, "R4 full kept on third write");
  endtask

  task automatic t_par_read();
    par_read(); chk(dout, 18'h00011, "R5 read empty first");
    par_read(); chk(dout, 18'h00ABC, "R5 read full second");
    par_read(); chk(dout, 18'h00011, "R5 read pointer wraps");
    step();     chk(dout, 18'h00011, "R5 dout holds without read");
  endtask

  task automatic t_wrong_serial();
    ser_load(13'h0000, 13'h0000);
    chk(empty_ofs, 13'h0011, "R7 serial ignored in parallel mode (empty)");
    chk(full_ofs, 13'h0ABC, "R7 serial ignored in parallel mode (full)");
  endtask

  task automatic t_deselected();
    ofs_sel_n = 1; wr_en_n = 0; rd_en_n = 0; ser_en_n = 0; din = 18'h00777;
    step(); step(); step(); idle();
    chk(empty_ofs, 13'h0011, "R8 empty unchanged while deselected");
    chk(full_ofs, 13'h0ABC, "R8 full unchanged while deselected");
    chk(dout, 18'h00011, "R8 dout unchanged while deselected");
  endtask

  task automatic t_collision();
    do_mrst(1'b0);
    ofs_sel_n = 0; wr_en_n = 0; rd_en_n = 0; din = 18'h00055; step(); idle();
    chk(dout, 127, "R9 same-edge read returns old value");
    chk(empty_ofs, 13'h0055, "R9 same-edge write lands");
    par_read(); chk(dout, 127, "R9 read pointer advanced once");
    par_read(); chk(dout, 18'h00055, "R9 new value read back");
  endtask

  task automatic t_partial();
    par_write(18'h00100);
    chk(full_ofs, 13'h0100, "R4 write went to full");
    par_read();
    prst = 1; step(); idle();
    chk(empty_ofs, 13'h0055, "R3 empty kept by partial reset");
    chk(full_ofs, 13'h0100, "R3 full kept by partial reset");
    chk(dout, 0, "R3 dout cleared");
    par_write(18'h00222);
    chk(empty_ofs, 13'h0222, "R3 write pointer restarted");
    par_read(); chk(dout, 18'h00222, "R3 read pointer restarted");
  endtask

  task automatic t_serial();
    do_mrst(1'b1);
    chk(empty_ofs, 1023, "R2 empty default");
    chk(full_ofs, 1023, "R2 full default");
    par_write(18'h00123);
    chk(empty_ofs, 1023, "R7 parallel write ignored in serial mode");
    chk(full_ofs, 1023, "R7 parallel write ignored (full)");
    ser_load(13'h0A5A, 13'h1357);
    chk(empty_ofs, 13'h0A5A, "R6 serial empty");
    chk(full_ofs, 13'h1357, "R6 serial full");
    for (int i = 0; i < 6; i++) begin
      ofs_sel_n = 0; ser_en_n = 1; ser_din = i[0]; step();
    end
    idle();
    chk(empty_ofs, 13'h0A5A, "R6 serial enable high keeps empty");
    chk(full_ofs, 13'h1357, "R6 serial enable high keeps full");
    par_read(); chk(dout, 18'h00A5A, "R5 read in serial mode");
    ser_load(13'h1111, 13'h0222);
    chk(empty_ofs, 13'h1111, "R6 sequence restarts after 2W bits");
    chk(full_ofs, 13'h0222, "R6 second serial full");
  endtask

  task automatic t_partial_serial();
    for (int i = 0; i < 5; i++) begin
      ofs_sel_n = 0; ser_en_n = 0; ser_din = 1; step();
    end
    idle();
    prst = 1; step(); idle();
    ser_load(13'h0123, 13'h0456);
    chk(empty_ofs, 13'h0123, "R3 serial position restarted, mode kept");
    chk(full_ofs, 13'h0456, "R3 serial full after partial reset");
  endtask

  task automatic t_priority();
    par_read();
    idle(); mrst = 1; prst = 1; ofs_sel_n = 0; step(); idle();
    chk(empty_ofs, 127, "R10 master reset wins over partial");
    chk(dout, 0, "R10 dout cleared");
    par_write(18'h00042);
    chk(empty_ofs, 13'h0042, "R10 parallel mode after master reset");
  endtask

  initial begin
    @(negedge clk);
    t_reset_par();
    t_par_write();
    t_par_read();
    t_wrong_serial();
    t_deselected();
    t_collision();
    t_partial();
    t_serial();
    t_partial_serial();
    t_priority();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule